// File: doc/BRIEF.md
# Debug Data Watchpoint Comparator

This block watches the load and store traffic of a processor data port and records debug hits. It has two compare channels. Each channel holds an address register and a 32-bit value register. An access is offered as an address, a data word and a write flag, qualified by a valid strobe. A channel fires when three conditions hold: the access address matches, the access direction is enabled for that channel, and, if value compare is on, the selected data bytes also agree with the value register.

Address matching has two forms. In exact mode, each channel compares the full address against its own register. In range mode, the two address registers form an inclusive lower bound (channel 0) and upper bound (channel 1). A hit in range mode applies to both channels, and each channel then applies its own direction and value qualifiers.

Hits set sticky read-hit and write-hit flags, one pair per channel. A small word-addressed register port gives software access to the configuration and lets it clear the flags.

Top module: `dbg_watch_top`

## Requirements
- R1: After reset, every register reads as zero and no hit flag is set.
- R2: The register port decodes these word offsets: 0 is the channel 0 address, 1 is the channel 1 address, 2 is the channel 0 value, 3 is the channel 1 value, 4 is control and 5 is status. Offsets 0 to 4 read back what was last written to them. Control has one byte per channel, at bits [7:0] for channel 0 and bits [15:8] for channel 1. Within that byte, bit 0 is the load enable, bit 1 is the store enable, bits [5:2] are the byte enables and bits [7:6] are the compare mode. Control bit 16 selects range mode.
- R3: In exact mode with value compare off, a load to an address equal to the channel's address register sets that channel's read flag if its load enable is 1. A store to that address sets the channel's write flag if its store enable is 1. An access to a different address sets no flag. Status holds the channel 0 read flag in bit 0, the channel 0 write flag in bit 1, the channel 1 read flag in bit 2 and the channel 1 write flag in bit 3.
- R4: A load never sets a write flag, and a store never sets a read flag. A direction whose enable is 0 sets nothing.
- R5: In range mode, an address A hits both channels when the channel 0 address ≤ A ≤ the channel 1 address. An address outside that range hits neither channel.
- R6: With mode 2'b01 and a nonzero byte enable, a flag is set only if every selected data byte equals the matching byte of the value register.
- R7: With mode 2'b10 and a nonzero byte enable, a flag is set if at least one selected data byte equals its value byte.
- R8: Value compare is off when the byte enable is 0 or the mode is 2'b00 or 2'b11. In that case the address match alone decides the hit.
- R9: Byte enable bit 0 selects data bits [31:24], and byte enable bit 3 selects data bits [7:0].
- R10: A flag changes on the first rising clock edge at which valid is high. Before that edge it still shows its old value. An access with valid low, or an access that does not hit, leaves every flag unchanged.
- R11: Writing a 1 to a status bit clears that flag, and writing a 0 leaves it unchanged. If a hit sets a flag in the same cycle that software clears it, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Access strobe |
| acc_write_i | input | 1 | 1 for a store, 0 for a load |
| acc_addr_i | input | ADDR_W | Data address of the access |
| acc_data_i | input | 32 | Data value of the access |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from reg_addr_i |

## Verification
A hit flag is due one clock edge after the access: the edge that samples valid high updates status, and nothing earlier does. Read data is combinational, so a status read made before that edge must still show the old value. The bench drives every input on the falling edge and samples read data shortly after the next falling edge. For one check it also reads status while the access is still pending, which proves the flag has not moved early. A register write takes effect at the rising edge inside its one-cycle window. A same-cycle clear and hit share one edge, and the bench reads the result only after that edge.

// File: rtl/dbg_watch_pkg.sv
package dbg_watch_pkg;
  localparam int unsigned NUM_CH = 2;
  localparam int unsigned CMP_W  = 32;
  localparam int unsigned NB     = CMP_W / 8;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned RA_W   = 3;
  localparam int unsigned ST_W   = 2 * NUM_CH;
  localparam int unsigned CFG_W  = 4 + NB;
  localparam int unsigned RANGE_BIT = NUM_CH * 8;

  localparam logic [RA_W-1:0] OFF_ADDR   = 3'd0;
  localparam logic [RA_W-1:0] OFF_VAL    = 3'd2;
  localparam logic [RA_W-1:0] OFF_CTRL   = 3'd4;
  localparam logic [RA_W-1:0] OFF_STATUS = 3'd5;

  typedef enum logic [1:0] {
    VM_OFF0 = 2'b00,
    VM_ALL  = 2'b01,
    VM_ANY  = 2'b10,
    VM_OFF3 = 2'b11
  } vmode_e;

  typedef struct packed {
    vmode_e        mode;
    logic [NB-1:0] be;
    logic          wr_en;
    logic          rd_en;
  } ch_cfg_t;
endpackage

// File: rtl/dbg_watch_regs.sv
module dbg_watch_regs
  import dbg_watch_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              we_i,
  input  logic [RA_W-1:0]                   addr_i,
  input  logic [REG_W-1:0]                  wdata_i,
  input  logic [ST_W-1:0]                   set_i,
  output logic [NUM_CH-1:0][ADDR_W-1:0]     base_o,
  output logic [NUM_CH-1:0][CMP_W-1:0]      val_o,
  output ch_cfg_t [NUM_CH-1:0]              cfg_o,
  output logic                              range_o,
  output logic [ST_W-1:0]                   status_o,
  output logic [REG_W-1:0]                  rdata_o
);
  logic [NUM_CH-1:0][ADDR_W-1:0] base_q;
  logic [NUM_CH-1:0][CMP_W-1:0]  val_q;
  logic [RANGE_BIT:0]            ctrl_q;
  logic [ST_W-1:0]               status_q, st_clr;
  logic                          st_wr;

  assign st_wr  = we_i && (addr_i == OFF_STATUS);
  assign st_clr = st_wr ? wdata_i[ST_W-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      val_q  <= '0;
      ctrl_q <= '0;
    end else if (we_i) begin
      for (int k = 0; k < NUM_CH; k++) begin
        if (addr_i == OFF_ADDR + RA_W'(k)) base_q[k] <= wdata_i[ADDR_W-1:0];
        if (addr_i == OFF_VAL + RA_W'(k))  val_q[k]  <= wdata_i[CMP_W-1:0];
      end
      if (addr_i == OFF_CTRL) ctrl_q <= wdata_i[RANGE_BIT:0];
    end
  end

  // hardware set beats software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~st_clr) | set_i;
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NUM_CH; k++) begin
      if (addr_i == OFF_ADDR + RA_W'(k)) rdata_o = REG_W'(base_q[k]);
      if (addr_i == OFF_VAL + RA_W'(k))  rdata_o = REG_W'(val_q[k]);
    end
    if (addr_i == OFF_CTRL)   rdata_o = REG_W'(ctrl_q);
    if (addr_i == OFF_STATUS) rdata_o = REG_W'(status_q);
  end

  for (genvar k = 0; k < NUM_CH; k++) begin : g_cfg
    assign cfg_o[k] = ch_cfg_t'(ctrl_q[k*8 +: CFG_W]);
  end

  assign base_o   = base_q;
  assign val_o    = val_q;
  assign range_o  = ctrl_q[RANGE_BIT];
  assign status_o = status_q;

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((status_q & $past(set_i)) == $past(set_i))); // R11
  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i == '0 && !st_wr) |=> $stable(status_q)); // R10
endmodule

// File: rtl/dbg_watch_addr.sv
module dbg_watch_addr
  import dbg_watch_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [NUM_CH-1:0][ADDR_W-1:0] base_i,
  input  logic                          range_i,
  output logic [NUM_CH-1:0]             hit_o
);
  logic in_range;

  assign in_range = (addr_i >= base_i[0]) && (addr_i <= base_i[NUM_CH-1]);

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    assign hit_o[k] = range_i ? in_range : (addr_i == base_i[k]);
  end
endmodule

// File: rtl/dbg_watch_chan.sv
module dbg_watch_chan
  import dbg_watch_pkg::*;
(
  input  ch_cfg_t          cfg_i,
  input  logic [CMP_W-1:0] val_i,
  input  logic [CMP_W-1:0] data_i,
  input  logic             addr_hit_i,
  input  logic             valid_i,
  input  logic             write_i,
  output logic             set_rd_o,
  output logic             set_wr_o
);
  logic [NB-1:0] lane_eq;
  logic          v_on, v_hit, qual;

  // enable bit 0 is the most significant byte
  for (genvar b = 0; b < NB; b++) begin : g_lane
    localparam int unsigned HI = CMP_W - 1 - 8*b;
    assign lane_eq[b] = data_i[HI -: 8] == val_i[HI -: 8];
  end

  assign v_on = (|cfg_i.be) && (cfg_i.mode == VM_ALL || cfg_i.mode == VM_ANY);

  always_comb begin
    unique case (cfg_i.mode)
      VM_ALL:  v_hit = &(lane_eq | ~cfg_i.be);
      VM_ANY:  v_hit = |(lane_eq & cfg_i.be);
      default: v_hit = 1'b1;
    endcase
  end

  assign qual     = valid_i && addr_hit_i && (!v_on || v_hit);
  assign set_rd_o = qual && !write_i && cfg_i.rd_en;
  assign set_wr_o = qual &&  write_i && cfg_i.wr_en;
endmodule

// File: rtl/dbg_watch_top.sv
module dbg_watch_top
  import dbg_watch_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [CMP_W-1:0]  acc_data_i,
  input  logic              reg_we_i,
  input  logic [RA_W-1:0]   reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o
);
  logic [NUM_CH-1:0][ADDR_W-1:0] base;
  logic [NUM_CH-1:0][CMP_W-1:0]  val;
  ch_cfg_t [NUM_CH-1:0]          cfg;
  logic                          range_mode;
  logic [ST_W-1:0]               status, set;
  logic [NUM_CH-1:0]             addr_hit;

  dbg_watch_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .set_i(set), .base_o(base), .val_o(val), .cfg_o(cfg),
    .range_o(range_mode), .status_o(status), .rdata_o(reg_rdata_o)
  );

  dbg_watch_addr #(.ADDR_W(ADDR_W)) addr_i (
    .addr_i(acc_addr_i), .base_i(base), .range_i(range_mode), .hit_o(addr_hit)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    dbg_watch_chan chan_i (
      .cfg_i(cfg[k]), .val_i(val[k]), .data_i(acc_data_i),
      .addr_hit_i(addr_hit[k]), .valid_i(acc_valid_i), .write_i(acc_write_i),
      .set_rd_o(set[2*k]), .set_wr_o(set[2*k+1])
    );

    AST_RD_FROM_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(status[2*k]) |-> $past(acc_valid_i && !acc_write_i)); // R4
    AST_WR_FROM_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(status[2*k+1]) |-> $past(acc_valid_i && acc_write_i)); // R4
    AST_EXACT_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(status[2*k]) && !$past(range_mode)) |-> ($past(acc_addr_i) == $past(base[k]))); // R3
  end
endmodule

// File: tb/dbg_watch_top_tb_top.sv
module dbg_watch_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, write = 1'b0;
  logic [31:0] addr = '0, data = '0;
  logic        we = 1'b0;
  logic [2:0]  raddr = '0;
  logic [31:0] wdata = '0, rdata;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  dbg_watch_top dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .acc_valid_i(valid), .acc_write_i(write), .acc_addr_i(addr), .acc_data_i(data),
    .reg_we_i(we), .reg_addr_i(raddr), .reg_wdata_i(wdata), .reg_rdata_o(rdata)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; raddr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); raddr = a; #1; d = rdata;
  endtask

  task automatic acc(logic [31:0] a, logic [31:0] d, logic w);
    @(negedge clk); valid = 1'b1; addr = a; data = d; write = w;
    @(negedge clk); valid = 1'b0;
  endtask

  task automatic st_chk(string req, logic [31:0] exp);
    logic [31:0] v;
    rd(3'd5, v);
    check(req, v, exp);
  endtask

  logic [31:0] v;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // r1_ reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v); check("R1", v, 32'h0);
    end
    // r2_ readback
    wr(3'd0, 32'h1234_5678); wr(3'd1, 32'h9abc_def0);
    wr(3'd2, 32'hcafe_f00d); wr(3'd3, 32'h0bad_beef);
    wr(3'd4, 32'h0001_a5c3);
    rd(3'd0, v); check("R2", v, 32'h1234_5678);
    rd(3'd1, v); check("R2", v, 32'h9abc_def0);
    rd(3'd2, v); check("R2", v, 32'hcafe_f00d);
    rd(3'd3, v); check("R2", v, 32'h0bad_beef);
    rd(3'd4, v); check("R2", v, 32'h0001_a5c3);
    // R3 exact match, ch0 load+store enabled
    wr(3'd4, 32'h0000_0003); wr(3'd0, 32'h0000_1000); wr(3'd1, 32'h0000_2000);
    wr(3'd5, 32'hf);
    acc(32'h1000, 32'h0, 1'b0); st_chk("R3 load hit", 32'h1);
    acc(32'h1000, 32'h0, 1'b1); st_chk("R3 store hit", 32'h3);
    wr(3'd5, 32'hf);
    acc(32'h1004, 32'h0, 1'b0); acc(32'h1004, 32'h0, 1'b1);
    st_chk("R3 miss", 32'h0);
    // R4 direction gating, ch0 load only, ch1 store only
    wr(3'd4, 32'h0000_0201);
    acc(32'h1000, 32'h0, 1'b1); st_chk("R4 store no rd", 32'h0);
    acc(32'h2000, 32'h0, 1'b0); st_chk("R4 load no wr", 32'h0);
    acc(32'h2000, 32'h0, 1'b1); st_chk("R4 ch1 store", 32'h8);
    wr(3'd5, 32'hf);
    // R5 range mode 0x100..0x1ff
    wr(3'd0, 32'h100); wr(3'd1, 32'h1ff); wr(3'd4, 32'h0001_0101);
    begin
      logic [31:0] pts [6] = '{32'hff, 32'h100, 32'h150, 32'h1ff, 32'h200, 32'h0};
      for (int i = 0; i < 6; i++) begin
        wr(3'd5, 32'hf);
        acc(pts[i], 32'h0, 1'b0);
        st_chk("R5", (pts[i] >= 32'h100 && pts[i] <= 32'h1ff) ? 32'h5 : 32'h0);
      end
    end
    wr(3'd5, 32'hf);
    // R9 lane mapping, AND mode ch0
    wr(3'd4, 32'h0); wr(3'd0, 32'h40);
    wr(3'd2, 32'hAA00_0000); wr(3'd4, {24'h0, 2'b01, 4'b0001, 2'b01});
    acc(32'h40, 32'hAA12_3456, 1'b0); st_chk("R9 bit0 msb hit", 32'h1);
    wr(3'd5, 32'hf);
    acc(32'h40, 32'h0000_00AA, 1'b0); st_chk("R9 bit0 msb miss", 32'h0);
    wr(3'd2, 32'h0000_00AA); wr(3'd4, {24'h0, 2'b01, 4'b1000, 2'b01});
    acc(32'h40, 32'h1234_56AA, 1'b0); st_chk("R9 bit3 lsb hit", 32'h1);
    wr(3'd5, 32'hf);
    acc(32'h40, 32'hAA00_0000, 1'b0); st_chk("R9 bit3 lsb miss", 32'h0);
    // R6 R7 R8 sweep: mode x byte enable x mismatching lanes
    wr(3'd2, 32'h1122_3344);
    for (int md = 0; md < 4; md++)
      for (int be = 0; be < 16; be++) begin
        wr(3'd4, {24'h0, 2'(md), 4'(be), 2'b01});
        for (int m = 0; m < 16; m++) begin
          logic [31:0] d;
          bit von, hit;
          d = 32'h1122_3344;
          for (int b = 0; b < 4; b++) if (m[b]) d[31-8*b -: 8] = ~d[31-8*b -: 8];
          von = (be != 0) && (md == 1 || md == 2);
          if (!von)         hit = 1'b1;
          else if (md == 1) hit = ((m & be) == 0);
          else              hit = ((be & ~m) != 0);
          wr(3'd5, 32'hf);
          acc(32'h40, d, 1'b0);
          rd(3'd5, v);
          check(!von ? "R8" : (md == 1 ? "R6" : "R7"), v, hit ? 32'h1 : 32'h0);
        end
      end
    // R10 timing and stickiness
    wr(3'd4, 32'h1); wr(3'd5, 32'hf);
    @(negedge clk); valid = 1'b1; write = 1'b0; addr = 32'h40; raddr = 3'd5;
    #1 check("R10 before edge", rdata, 32'h0);
    @(negedge clk); valid = 1'b0;
    #1 check("R10 after edge", rdata, 32'h1);
    acc(32'h44, 32'h0, 1'b0); st_chk("R10 sticky miss", 32'h1);
    wr(3'd5, 32'hf);
    @(negedge clk); valid = 1'b0; addr = 32'h40; write = 1'b0;
    @(negedge clk); st_chk("R10 valid low", 32'h0);
    // R11 W1C and set priority
    wr(3'd4, 32'h3);
    acc(32'h40, 32'h0, 1'b0); acc(32'h40, 32'h0, 1'b1);
    wr(3'd5, 32'h1); st_chk("R11 clear one", 32'h2);
    wr(3'd5, 32'h0); st_chk("R11 write zero", 32'h2);
    acc(32'h40, 32'h0, 1'b0);
    @(negedge clk); valid = 1'b1; addr = 32'h40; write = 1'b0;
    we = 1'b1; raddr = 3'd5; wdata = 32'h1;
    @(negedge clk); valid = 1'b0; we = 1'b0;
    st_chk("R11 set wins", 32'h3);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule